// File: doc/BRIEF.md
# Thermally Triggered Core Swap Controller

This controller sits beside two identical processor cores that share a level-one cache fabric. It watches a digital temperature code from each core. When the core that currently runs the workload gets too hot, it moves the workload to the other core. The receiving core then runs until it overheats in turn, and the workload moves back.

A swap has a fixed order. First, a flush request drains the outgoing core's pipeline. Once the flush is acknowledged, the incoming core receives a one-cycle start pulse. In the same cycle, two transfers begin together. A copy engine streams every architectural register from the outgoing core into the incoming one, one entry per clock. A writeback request asks the outgoing core to push its dirty private-cache lines into the shared cache. Neither transfer delays the start pulse. The active-core select flips only after the flush acknowledge, the last register write and the writeback completion have all been seen.

The sequencer has four states. RUN monitors the active core's temperature. FLUSH holds the flush request. LAUNCH lasts one cycle: it issues the start pulse, launches the copy and raises the writeback request. XFER waits for both transfers. The transitions are:

- RUN to FLUSH, on a hot reading from the active core.
- FLUSH to LAUNCH, on the flush acknowledge.
- LAUNCH to XFER, unconditionally.
- XFER to RUN, once the copy and the writeback are both done. The select flips on this transition.

Top module: `thermal_core_swap`

## Requirements
- R1: After reset, `active_sel` is 0 (core 0 runs the workload) and `flush_req`, `core_start`, `wb_req`, `rf_rd_en` and `rf_wr_en` are all 0.
- R2: A temperature code is an 8-bit unsigned value in whole degrees Celsius, and it counts only in a cycle where its valid strobe is 1. A valid code from the active core that is at least 82 raises `flush_req` in the next cycle. Each of the following leaves `flush_req` at 0: a valid code of 81, a code of any value whose strobe is 0, or any code from the idle core.
- R3: `flush_req` stays 1 until `flush_ack` is sampled as 1, and `core_start` stays 0 while the flush is outstanding.
- R4: `core_start` is a single-cycle pulse in the cycle after `flush_ack` is sampled. `wb_req` rises in that same cycle. The register reads begin in the next cycle, so the start pulse does not wait for the state transfer.
- R5: The copy reads entries 0 to 127 of the outgoing core (selected by the current `active_sel`) in increasing order, one per cycle. Read data arrive one cycle after each read. Each entry is written to the same index of the incoming core one cycle after its read, for exactly 128 writes.
- R6: `wb_req` stays 1 until `wb_done` is sampled as 1, and then falls.
- R7: `active_sel` flips in the cycle after the later of two events: the 128th register write, and `wb_done` being sampled. The writeback may finish before or after the copy.
- R8: While a swap is in progress, any hot reading from either core is ignored: no new flush is raised, either during the swap or after it completes. Once back in RUN, only the new active core's readings are monitored.
- R9: A hot reading from the new active core starts the next swap, which moves the workload back to the first core.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp0_code | input | 8 | Temperature code of core 0, degrees C |
| temp0_vld | input | 1 | Core 0 code valid strobe |
| temp1_code | input | 8 | Temperature code of core 1, degrees C |
| temp1_vld | input | 1 | Core 1 code valid strobe |
| flush_req | output | 1 | Flush request to the outgoing core |
| flush_ack | input | 1 | Flush complete from the outgoing core |
| core_start | output | 1 | Start pulse to the incoming core |
| rf_rd_en | output | 1 | Register read strobe to the outgoing core |
| rf_rd_idx | output | 7 | Register read index |
| rf_rd_data | input | 32 | Register read data, one cycle after the read |
| rf_wr_en | output | 1 | Register write strobe to the incoming core |
| rf_wr_idx | output | 7 | Register write index |
| rf_wr_data | output | 32 | Register write data |
| wb_req | output | 1 | Dirty-line writeback request to the outgoing core |
| wb_done | input | 1 | Writeback complete |
| active_sel | output | 1 | Core running the workload (0 or 1) |

## Verification
The hardest situation to reach is the overlap of a swap with other events. A threshold crossing can arrive while a swap is in flight, and the writeback can complete on either side of the last register write. The stimulus gets there with a scenario task that runs a swap cycle by cycle. In the fifth cycle after the start pulse it injects hot readings from both cores, and it places `wb_done` either early (cycle 3) or late (cycle 150, after the copy ends at cycle 129). After each swap, it checks the exact cycle of the select flip, the full register image of the incoming core, and the absence of any follow-on flush.

// File: rtl/thermal_core_swap_pkg.sv
package thermal_core_swap_pkg;
    localparam int NUM_CORES = 2;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_FLUSH  = 2'd1,
        ST_LAUNCH = 2'd2,
        ST_XFER   = 2'd3
    } swap_state_e;
endpackage

// File: rtl/swap_thermal_watch.sv
module swap_thermal_watch
    import thermal_core_swap_pkg::*;
#(
    parameter int TEMP_W    = 8,
    parameter int CRIT_TEMP = 82
) (
    input  logic [NUM_CORES-1:0][TEMP_W-1:0] codes,
    input  logic [NUM_CORES-1:0]             vlds,
    input  logic                             sel,
    output logic                             hot
);
    localparam logic [TEMP_W-1:0] LIMIT = TEMP_W'(CRIT_TEMP);

    logic [NUM_CORES-1:0] over;

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        assign over[g] = vlds[g] && (codes[g] >= LIMIT);
    end

    // only the core running the workload can trigger a swap
    assign hot = over[sel];
endmodule

// File: rtl/swap_regcopy.sv
module swap_regcopy #(
    parameter int REGS   = 128,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       go,
    output logic                       rd_en,
    output logic [$clog2(REGS)-1:0]    rd_idx,
    input  logic [DATA_W-1:0]          rd_data,
    output logic                       wr_en,
    output logic [$clog2(REGS)-1:0]    wr_idx,
    output logic [DATA_W-1:0]          wr_data,
    output logic                       done
);
    localparam int IDX_W = $clog2(REGS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(REGS - 1);

    logic             busy_q;
    logic [IDX_W-1:0] cnt_q;
    logic             wv_q;
    logic [IDX_W-1:0] wi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            wv_q   <= 1'b0;
            wi_q   <= '0;
        end else begin
            // write stage trails the read stage by the read latency
            wv_q <= busy_q;
            wi_q <= cnt_q;
            if (go) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end else if (busy_q) begin
                if (cnt_q == LAST) begin
                    busy_q <= 1'b0;
                end
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign rd_en   = busy_q;
    assign rd_idx  = cnt_q;
    assign wr_en   = wv_q;
    assign wr_idx  = wi_q;
    assign wr_data = rd_data;
    assign done    = wv_q && (wi_q == LAST);

    a_r5_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_idx == $past(rd_idx) + 1'b1));

    a_r5_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> (rd_idx == '0));

    a_r5_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(rd_en) && (wr_idx == $past(rd_idx))));
endmodule

// File: rtl/swap_seq.sv
module swap_seq
    import thermal_core_swap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hot,
    input  logic flush_ack,
    input  logic copy_done,
    input  logic wb_done,
    output logic flush_req,
    output logic core_start,
    output logic copy_go,
    output logic wb_req,
    output logic active_sel
);
    swap_state_e state_q, state_d;
    logic        cp_seen_q;
    logic        wb_seen_q;
    logic        sel_q;
    logic        all_done;

    assign all_done = (cp_seen_q || copy_done) && (wb_seen_q || wb_done);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // completion flags and active select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cp_seen_q <= 1'b0;
            wb_seen_q <= 1'b0;
            sel_q     <= 1'b0;
        end else begin
            if (state_q == ST_RUN) begin
                cp_seen_q <= 1'b0;
                wb_seen_q <= 1'b0;
            end else begin
                if (copy_done) cp_seen_q <= 1'b1;
                if (wb_done && (state_q == ST_LAUNCH || state_q == ST_XFER))
                    wb_seen_q <= 1'b1;
            end
            if (state_q == ST_XFER && all_done) begin
                sel_q <= ~sel_q;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        flush_req  = 1'b0;
        core_start = 1'b0;
        copy_go    = 1'b0;
        wb_req     = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (hot) state_d = ST_FLUSH;
            end
            ST_FLUSH: begin
                flush_req = 1'b1;
                if (flush_ack) state_d = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                core_start = 1'b1;
                copy_go    = 1'b1;
                wb_req     = ~wb_seen_q;
                state_d    = ST_XFER;
            end
            ST_XFER: begin
                wb_req = ~wb_seen_q;
                if (all_done) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    assign active_sel = sel_q;

    a_r3_flush_held: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_ack) |=> flush_req);

    a_r4_start_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> $past(flush_req && flush_ack));

    a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);

    a_r6_wb_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_done) |=> wb_req);

    a_r7_flip_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_sel) |-> $past(state_q == ST_XFER && all_done));

    a_r8_flush_only_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_req) |-> $past(state_q == ST_RUN && hot));
endmodule

// File: rtl/thermal_core_swap.sv
module thermal_core_swap
    import thermal_core_swap_pkg::*;
#(
    parameter int TEMP_W    = 8,
    parameter int CRIT_TEMP = 82,
    parameter int REGS      = 128,
    parameter int DATA_W    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [TEMP_W-1:0]         temp0_code,
    input  logic                      temp0_vld,
    input  logic [TEMP_W-1:0]         temp1_code,
    input  logic                      temp1_vld,
    output logic                      flush_req,
    input  logic                      flush_ack,
    output logic                      core_start,
    output logic                      rf_rd_en,
    output logic [$clog2(REGS)-1:0]   rf_rd_idx,
    input  logic [DATA_W-1:0]         rf_rd_data,
    output logic                      rf_wr_en,
    output logic [$clog2(REGS)-1:0]   rf_wr_idx,
    output logic [DATA_W-1:0]         rf_wr_data,
    output logic                      wb_req,
    input  logic                      wb_done,
    output logic                      active_sel
);
    logic [NUM_CORES-1:0][TEMP_W-1:0] codes;
    logic [NUM_CORES-1:0]             vlds;
    logic                             hot;
    logic                             copy_go;
    logic                             copy_done;

    assign codes = {temp1_code, temp0_code};
    assign vlds  = {temp1_vld, temp0_vld};

    swap_thermal_watch #(
        .TEMP_W    (TEMP_W),
        .CRIT_TEMP (CRIT_TEMP)
    ) u_watch (
        .codes (codes),
        .vlds  (vlds),
        .sel   (active_sel),
        .hot   (hot)
    );

    swap_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hot        (hot),
        .flush_ack  (flush_ack),
        .copy_done  (copy_done),
        .wb_done    (wb_done),
        .flush_req  (flush_req),
        .core_start (core_start),
        .copy_go    (copy_go),
        .wb_req     (wb_req),
        .active_sel (active_sel)
    );

    swap_regcopy #(
        .REGS   (REGS),
        .DATA_W (DATA_W)
    ) u_copy (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (copy_go),
        .rd_en   (rf_rd_en),
        .rd_idx  (rf_rd_idx),
        .rd_data (rf_rd_data),
        .wr_en   (rf_wr_en),
        .wr_idx  (rf_wr_idx),
        .wr_data (rf_wr_data),
        .done    (copy_done)
    );

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_rd_en || rf_wr_en) |-> !flush_req);
endmodule

// File: tb/thermal_core_swap_tb.sv
module thermal_core_swap_tb;
    localparam int NREG = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  temp0_code = '0, temp1_code = '0;
    logic        temp0_vld = 1'b0, temp1_vld = 1'b0;
    logic        flush_req, flush_ack = 1'b0;
    logic        core_start;
    logic        rf_rd_en, rf_wr_en;
    logic [6:0]  rf_rd_idx, rf_wr_idx;
    logic [31:0] rf_rd_data, rf_wr_data;
    logic        wb_req, wb_done = 1'b0;
    logic        active_sel;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [31:0] rf [2][NREG];
    logic [31:0] rd_q = '0;

    always #2.5 clk = ~clk;

    thermal_core_swap u_dut (
        .clk(clk), .rst_n(rst_n),
        .temp0_code(temp0_code), .temp0_vld(temp0_vld),
        .temp1_code(temp1_code), .temp1_vld(temp1_vld),
        .flush_req(flush_req), .flush_ack(flush_ack),
        .core_start(core_start),
        .rf_rd_en(rf_rd_en), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .wb_req(wb_req), .wb_done(wb_done),
        .active_sel(active_sel)
    );

    // register files of the two cores, synchronous read
    assign rf_rd_data = rd_q;
    always @(posedge clk) begin
        if (rf_rd_en) rd_q <= rf[active_sel][rf_rd_idx];
        if (rf_wr_en) rf[~active_sel][rf_wr_idx] <= rf_wr_data;
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary_and_end();
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 100000) begin
                checks++;
                fails++;
                $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
                summary_and_end();
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_temp(input int core, input logic [7:0] code, input logic vld);
        if (core == 0) begin temp0_code = code; temp0_vld = vld; end
        else           begin temp1_code = code; temp1_vld = vld; end
    endtask

    task automatic clear_temps();
        temp0_vld = 1'b0; temp1_vld = 1'b0; temp0_code = '0; temp1_code = '0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(active_sel == 1'b0, "R1 active_sel", active_sel, 0);
        chk({flush_req, core_start, wb_req, rf_rd_en, rf_wr_en} == 5'b0,
            "R1 outputs idle", {flush_req, core_start, wb_req, rf_rd_en, rf_wr_en}, 0);
    endtask

    // readings that must not start a swap; active core is 0 here
    task automatic t_no_trigger();
        set_temp(0, 8'd81, 1'b1);
        @(negedge clk); clear_temps();
        chk(flush_req == 1'b0, "R2 code 81 ignored", flush_req, 0);
        set_temp(1, 8'd200, 1'b1);
        @(negedge clk); clear_temps();
        chk(flush_req == 1'b0, "R2 idle core ignored", flush_req, 0);
        set_temp(0, 8'd150, 1'b0);
        @(negedge clk); clear_temps();
        chk(flush_req == 1'b0, "R2 strobe low ignored", flush_req, 0);
        @(negedge clk);
        chk(flush_req == 1'b0, "R2 still idle", flush_req, 0);
    endtask

    // one full swap away from core 'from'
    task automatic t_swap(input int from, input int seed, input int ack_at,
                          input int wb_at, input bit hot_mid, input int hot_code);
        int to = 1 - from;
        int wcount = 0, bad_order = 0, bad_wb = 0, bad_start = 0, bad_flush = 0;
        int flip_at = -1, exp_flip, mism = 0;
        for (int i = 0; i < NREG; i++) begin
            rf[from][i] = 32'hA500_0000 ^ (seed << 12) ^ i;
            rf[to][i]   = '0;
        end
        set_temp(from, 8'(hot_code), 1'b1);
        @(negedge clk); clear_temps();
        chk(flush_req == 1'b1, (from == 0) ? "R2 hot raises flush" : "R9 swap back flush",
            flush_req, 1);
        for (int k = 0; k < ack_at; k++) begin
            @(negedge clk);
            if (!flush_req || core_start) bad_flush++;
        end
        chk(bad_flush == 0, "R3 flush held, no start", bad_flush, 0);
        flush_ack = 1'b1;
        exp_flip = ((wb_at > 129) ? wb_at : 129) + 1;
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            flush_ack = 1'b0;
            if (n == 0) begin
                chk(core_start && wb_req && !flush_req, "R4 start and wb_req together",
                    {core_start, wb_req, flush_req}, 3'b110);
                chk(rf_rd_en == 1'b0, "R4 reads follow start", rf_rd_en, 0);
            end else if (core_start) bad_start++;
            if (n == 1) chk(rf_rd_en && rf_rd_idx == 0, "R4 copy begins", rf_rd_idx, 0);
            if (active_sel != from[0]) begin flip_at = n; break; end
            if (rf_wr_en) begin
                if (rf_wr_idx != wcount[6:0]) bad_order++;
                wcount++;
            end
            if ((n <= wb_at) != wb_req) bad_wb++;
            if (flush_req) bad_flush++;
            wb_done = (n == wb_at);
            if (hot_mid && n == 5) begin
                set_temp(0, 8'd120, 1'b1); set_temp(1, 8'd120, 1'b1);
            end else clear_temps();
        end
        wb_done = 1'b0;
        clear_temps();
        chk(bad_start == 0, "R4 start single pulse", bad_start, 0);
        chk(flip_at == exp_flip, "R7 select flip cycle", flip_at, exp_flip);
        chk(wcount == NREG, "R5 write count", wcount, NREG);
        chk(bad_order == 0, "R5 write order", bad_order, 0);
        for (int i = 0; i < NREG; i++) if (rf[to][i] != rf[from][i]) mism++;
        chk(mism == 0, "R5 image copied", mism, 0);
        chk(bad_wb == 0, "R6 wb_req held until done", bad_wb, 0);
        chk(bad_flush == 0, "R8 no flush inside swap", bad_flush, 0);
        @(negedge clk);
        chk(flush_req == 1'b0 && !wb_req, "R8 nothing pending after swap",
            {flush_req, wb_req}, 0);
        // the previous core is now idle: its readings must be ignored
        set_temp(from, 8'd130, 1'b1);
        @(negedge clk); clear_temps();
        chk(flush_req == 1'b0, "R8 old core ignored", flush_req, 0);
        chk(active_sel == to[0], "R9 workload on new core", active_sel, to);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_no_trigger();
        t_swap(0, 1, 2, 3, 1'b1, 82);      // early writeback, hot readings mid-swap
        t_swap(1, 2, 0, 150, 1'b0, 95);    // late writeback, immediate ack, swap back
        t_swap(0, 3, 5, 129, 1'b1, 255);   // writeback and copy end together
        repeat (2) @(negedge clk);
        summary_and_end();
    end
endmodule